// File: doc/BRIEF.md
# Deferrable Row-Activate Refresh Scheduler

This block keeps DRAM contents alive without ever using the device's built-in refresh command. A DRAM backend serves several independent resources in a fixed rotation, and each resource owns two banks of one rank. The scheduler watches that rotation. For each resource it counts that resource's access slots. When a fixed number of them has gone by, it claims one slot and marks it as a refresh. The command generator then fills that slot with a plain row activate followed by an automatic precharge.

The scheduler chooses the row itself. Each resource has its own row pointer and a bank-select bit. The pointer visits bank 0 and then bank 1 of one row before moving on to the next row. It wraps after every row of both banks has been touched.

A refresh that comes due can be pushed back. If a load request is waiting on that slot, the refresh moves to the resource's next free slot. While a bulk transfer owns the resource, the refresh is held back and replayed at the first free slot after the transfer ends. At most one refresh can be owed at a time, so a refresh never adds to the latency of a waiting load.

Top module: `refresh_sched`

## Requirements
- R1: After reset, `ref_valid` stays low. Each resource's slot counter, owed flag and row pointer start at zero, so the first refresh of a resource lands on its LIM_BL4-th (or LIM_BL8-th) slot.
- R2: When `burst_mode` is 0 (burst length 4) and nothing blocks, a resource gets exactly one refresh on every 60th of its own slots (LIM_BL4).
- R3: When `burst_mode` is 1 (burst length 8) and nothing blocks, a resource gets exactly one refresh on every 39th of its own slots (LIM_BL8).
- R4: `ref_valid` is a one-cycle pulse in the cycle after a sampled `slot_go`. `ref_res` equals the `slot_res` value of that slot.
- R5: Each resource's refreshes follow the order (bank 0, row 0), (bank 1, row 0), (bank 0, row 1), and so on. After bank 1 of row ROWS-1 the order wraps to (bank 0, row 0). The pointer moves only when a refresh is issued.
- R6: No refresh is issued on a slot whose resource has `req_pending` set. A due refresh instead goes to that resource's next slot without a pending request.
- R7: No refresh is issued on a slot whose resource has `xfer_active` set. The held refresh is issued on the first slot of that resource after `xfer_active` drops, provided no request is pending on that slot.
- R8: At most one refresh is owed per resource. If two refresh periods expire while the resource is blocked, only one refresh is issued when it frees up.
- R9: Resources are independent. Slots, requests and transfers on one resource do not change when another resource is refreshed.
- R10: Suppose a resource is blocked for fewer slots than one refresh period, and its requests never cover two of its consecutive slots. Then that resource never goes more than two refresh periods of its own slots between refreshes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_go | input | 1 | An access slot starts this cycle |
| slot_res | input | RES_W | Resource that owns the starting slot |
| req_pending | input | NUM_RES | Per-resource flag: a load request waits for this resource |
| xfer_active | input | NUM_RES | Per-resource flag: a bulk transfer owns this resource |
| burst_mode | input | 1 | 0 = burst length 4 (LIM_BL4 period), 1 = burst length 8 (LIM_BL8 period) |
| ref_valid | output | 1 | The slot sampled in the previous cycle is a refresh slot |
| ref_res | output | RES_W | Resource of the refresh slot |
| ref_bank | output | 1 | Bank within the resource to activate |
| ref_row | output | ROW_W | Row to activate |

## Verification
The hardest case to reach is a resource that stays blocked through two consecutive expirations of its refresh period, because only then does the owed flag saturate. The stimulus holds a transfer on one resource for 130 of its slots, crossing the 60th and 120th. A neighbouring resource keeps free slots in the same rotation, so independence can be checked at the same time. The stimulus then releases the transfer and expects exactly one replayed refresh. Row wrap is reached by building the bench with only four rows per bank. Long random phases with bounded blocking then measure the worst refresh gap of every resource.

// File: rtl/rfr_pkg.sv
`timescale 1ns/1ps
package rfr_pkg;

    localparam int DEF_NUM_RES = 4;
    localparam int DEF_ROWS    = 8192;
    localparam int DEF_LIM_BL4 = 60;
    localparam int DEF_LIM_BL8 = 39;

    typedef enum logic {
        BURST_4 = 1'b0,
        BURST_8 = 1'b1
    } burst_mode_e;

    // What one lane sees of the current slot
    typedef struct packed {
        logic hit;
        logic blocked;
    } slot_view_t;

    function automatic int interval_of(burst_mode_e m, int l4, int l8);
        return (m == BURST_8) ? l8 : l4;
    endfunction

endpackage

// File: rtl/rfr_ticker.sv
`timescale 1ns/1ps
module rfr_ticker
    import rfr_pkg::*;
#(
    parameter int LIM4 = DEF_LIM_BL4,
    parameter int LIM8 = DEF_LIM_BL8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  burst_mode_e mode,
    output logic        due
);
    localparam int LIM_MAX = (LIM4 > LIM8) ? LIM4 : LIM8;
    localparam int CNT_W   = (LIM_MAX > 2) ? $clog2(LIM_MAX) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(interval_of(mode, LIM4, LIM8) - 1);
    // >= keeps a mode change mid-period from overrunning
    assign due  = step && (cnt_q >= last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= due ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/rfr_rowptr.sv
`timescale 1ns/1ps
module rfr_rowptr
    import rfr_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic             bank,
    output logic [ROW_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank <= 1'b0;
            row  <= '0;
        end else if (adv) begin
            if (bank) begin
                bank <= 1'b0;
                row  <= (row == ROW_W'(ROWS - 1)) ? '0 : row + 1'b1;
            end else begin
                bank <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rfr_lane.sv
`timescale 1ns/1ps
module rfr_lane
    import rfr_pkg::*;
#(
    parameter int ROWS = DEF_ROWS,
    parameter int LIM4 = DEF_LIM_BL4,
    parameter int LIM8 = DEF_LIM_BL8,
    localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  slot_view_t       view,
    input  burst_mode_e      mode,
    output logic             fire,
    output logic             bank,
    output logic [ROW_W-1:0] row
);
    logic due;
    logic owed_q;

    rfr_ticker #(.LIM4(LIM4), .LIM8(LIM8)) u_ticker (
        .clk  (clk),
        .rst  (rst),
        .step (view.hit),
        .mode (mode),
        .due  (due)
    );

    assign fire = view.hit && (owed_q || due) && !view.blocked;

    // Owed count saturates at one; a fresh due on a firing slot stays owed
    always_ff @(posedge clk) begin
        if (rst) begin
            owed_q <= 1'b0;
        end else if (view.hit) begin
            owed_q <= fire ? (owed_q && due) : (owed_q || due);
        end
    end

    rfr_rowptr #(.ROWS(ROWS)) u_rowptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (fire),
        .bank (bank),
        .row  (row)
    );
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched
    import rfr_pkg::*;
#(
    parameter int NUM_RES = DEF_NUM_RES,
    parameter int ROWS    = DEF_ROWS,
    parameter int LIM_BL4 = DEF_LIM_BL4,
    parameter int LIM_BL8 = DEF_LIM_BL8,
    localparam int RES_W  = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_go,
    input  logic [RES_W-1:0]   slot_res,
    input  logic [NUM_RES-1:0] req_pending,
    input  logic [NUM_RES-1:0] xfer_active,
    input  logic               burst_mode,
    output logic               ref_valid,
    output logic [RES_W-1:0]   ref_res,
    output logic               ref_bank,
    output logic [ROW_W-1:0]   ref_row
);
    burst_mode_e        mode;
    logic [NUM_RES-1:0] lane_fire;
    logic [NUM_RES-1:0] lane_bank;
    logic [ROW_W-1:0]   lane_row [NUM_RES];

    assign mode = burst_mode_e'(burst_mode);

    for (genvar g = 0; g < NUM_RES; g++) begin : g_lane
        slot_view_t view;
        assign view.hit     = slot_go && (slot_res == RES_W'(g));
        assign view.blocked = req_pending[g] || xfer_active[g];

        rfr_lane #(.ROWS(ROWS), .LIM4(LIM_BL4), .LIM8(LIM_BL8)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .view (view),
            .mode (mode),
            .fire (lane_fire[g]),
            .bank (lane_bank[g]),
            .row  (lane_row[g])
        );
    end

    // Pointer values are captured before the lane advances them
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_valid <= 1'b0;
            ref_res   <= '0;
            ref_bank  <= 1'b0;
            ref_row   <= '0;
        end else begin
            ref_valid <= |lane_fire;
            if (|lane_fire) begin
                ref_res  <= slot_res;
                ref_bank <= lane_bank[slot_res];
                ref_row  <= lane_row[slot_res];
            end
        end
    end
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
    parameter int NUM_RES = 4,
    parameter int ROWS    = 8192,
    localparam int RES_W  = (NUM_RES > 1) ? $clog2(NUM_RES) : 1,
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic               clk,
    input logic               rst,
    input logic               slot_go,
    input logic [RES_W-1:0]   slot_res,
    input logic [NUM_RES-1:0] req_pending,
    input logic [NUM_RES-1:0] xfer_active,
    input logic               ref_valid,
    input logic [RES_W-1:0]   ref_res,
    input logic               ref_bank,
    input logic [ROW_W-1:0]   ref_row
);
    logic               go_q;
    logic [RES_W-1:0]   res_q;
    logic [NUM_RES-1:0] blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q  <= 1'b0;
            res_q <= '0;
            blk_q <= '0;
        end else begin
            go_q  <= slot_go;
            res_q <= slot_res;
            blk_q <= req_pending | xfer_active;
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !ref_valid);

    assert_refresh_in_slot_R4: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (go_q && ref_res == res_q));

    // Covers R6 (request) and R7 (transfer) blocking
    assert_no_refresh_when_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> !blk_q[ref_res]);

    for (genvar g = 0; g < NUM_RES; g++) begin : g_order
        logic             seen_q;
        logic             lbank_q;
        logic [ROW_W-1:0] lrow_q;
        logic             mine;
        logic [ROW_W-1:0] row_after;

        assign mine      = ref_valid && (ref_res == RES_W'(g));
        assign row_after = (lrow_q == ROW_W'(ROWS - 1)) ? '0 : lrow_q + 1'b1;

        always_ff @(posedge clk) begin
            if (rst) begin
                seen_q  <= 1'b0;
                lbank_q <= 1'b0;
                lrow_q  <= '0;
            end else if (mine) begin
                seen_q  <= 1'b1;
                lbank_q <= ref_bank;
                lrow_q  <= ref_row;
            end
        end

        assert_first_row_R5: assert property (@(posedge clk) disable iff (rst)
            (mine && !seen_q) |-> (!ref_bank && ref_row == '0));

        assert_row_order_R5: assert property (@(posedge clk) disable iff (rst)
            (mine && seen_q) |->
                (ref_bank != lbank_q && ref_row == (lbank_q ? row_after : lrow_q)));
    end
endmodule

bind refresh_sched refresh_sched_chk #(.NUM_RES(NUM_RES), .ROWS(ROWS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_go     (slot_go),
    .slot_res    (slot_res),
    .req_pending (req_pending),
    .xfer_active (xfer_active),
    .ref_valid   (ref_valid),
    .ref_res     (ref_res),
    .ref_bank    (ref_bank),
    .ref_row     (ref_row)
);

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
    localparam int NR   = 4;
    localparam int ROWS = 4;
    localparam int L4   = 60;
    localparam int L8   = 39;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       slot_go = 1'b0;
    logic [1:0] slot_res = '0;
    logic [3:0] req_pending = '0;
    logic [3:0] xfer_active = '0;
    logic       burst_mode = 1'b0;
    logic       ref_valid;
    logic [1:0] ref_res;
    logic       ref_bank;
    logic [1:0] ref_row;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_cnt [NR];
    int m_owed[NR];
    int m_iss [NR];
    int gap   [NR];
    bit e_v;
    int e_res, e_bank, e_row;

    always #10 clk = ~clk;

    refresh_sched #(.NUM_RES(NR), .ROWS(ROWS), .LIM_BL4(L4), .LIM_BL8(L8)) u_refresh_sched (
        .clk(clk), .rst(rst), .slot_go(slot_go), .slot_res(slot_res),
        .req_pending(req_pending), .xfer_active(xfer_active), .burst_mode(burst_mode),
        .ref_valid(ref_valid), .ref_res(ref_res), .ref_bank(ref_bank), .ref_row(ref_row)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit bl8);
        @(negedge clk);
        rst = 1'b1; slot_go = 0; req_pending = '0; xfer_active = '0; burst_mode = bl8;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < NR; r++) begin
            m_cnt[r] = 0; m_owed[r] = 0; m_iss[r] = 0; gap[r] = 0;
        end
    endtask

    // One cycle: drive, predict, sample one time unit after the edge, compare
    task automatic step(input bit go, input int res, input logic [3:0] req, input logic [3:0] xf);
        int  lim;
        bit  due, iss;
        @(negedge clk);
        slot_go = go; slot_res = res[1:0]; req_pending = req; xfer_active = xf;
        e_v = 0;
        if (go) begin
            lim = burst_mode ? L8 : L4;
            due = (m_cnt[res] >= lim - 1);
            m_cnt[res] = due ? 0 : m_cnt[res] + 1;
            iss = (m_owed[res] != 0 || due) && !(req[res] || xf[res]);
            if (iss) begin
                e_v = 1; e_res = res;
                e_bank = m_iss[res] % 2;
                e_row  = (m_iss[res] / 2) % ROWS;
                m_iss[res]++;
                m_owed[res] = (m_owed[res] != 0 && due) ? 1 : 0;
            end else begin
                m_owed[res] = (m_owed[res] != 0 || due) ? 1 : 0;
            end
            gap[res]++;
        end
        @(posedge clk);
        #1;
        chk(ref_valid === e_v, "R2/R6 refresh slot choice", int'(ref_valid), int'(e_v));
        if (e_v && ref_valid) begin
            chk(int'(ref_res) == e_res, "R4 refresh resource", int'(ref_res), e_res);
            chk(int'(ref_bank) == e_bank && int'(ref_row) == e_row,
                "R5 bank/row order", int'(ref_bank) * 100 + int'(ref_row), e_bank * 100 + e_row);
        end
    endtask

    int   n;
    int   seen2, seen3;
    int   last_b, last_r;
    int   xleft [NR];
    int   xcool [NR];
    logic [3:0] preq;

    initial begin
        // ---- R1 / R2 / R5 / R6 on resource 0, burst length 4
        do_reset(1'b0);
        step(0, 0, '0, '0);
        chk(ref_valid == 1'b0, "R1 idle after reset", int'(ref_valid), 0);
        n = 0;
        for (int i = 0; i < L4 - 1; i++) begin
            step(1, 0, '0, '0);
            if (ref_valid) n++;
        end
        chk(n == 0, "R1 no refresh before period", n, 0);
        step(1, 0, '0, '0);
        chk(ref_valid && ref_bank == 0 && ref_row == 0, "R2 refresh on 60th slot",
            int'(ref_valid), 1);
        for (int i = 0; i < L4 - 1; i++) step(1, 0, '0, '0);
        step(1, 0, 4'b0001, '0);
        chk(ref_valid == 1'b0, "R6 refresh yields to request", int'(ref_valid), 0);
        step(1, 0, '0, '0);
        chk(ref_valid && ref_bank == 1 && ref_row == 0, "R6 deferred refresh next slot",
            int'(ref_valid), 1);

        // ---- R3 on resource 1, burst length 8
        do_reset(1'b1);
        n = 0;
        for (int i = 0; i < L8 - 1; i++) begin
            step(1, 1, '0, '0);
            if (ref_valid) n++;
        end
        chk(n == 0, "R3 no refresh before 39th slot", n, 0);
        step(1, 1, '0, '0);
        chk(ref_valid == 1'b1, "R3 refresh on 39th slot", int'(ref_valid), 1);

        // ---- R7 / R8 / R9: long transfer on resource 2, free resource 3
        do_reset(1'b0);
        seen2 = 0; seen3 = 0;
        for (int i = 0; i < 130; i++) begin
            step(1, 2, '0, 4'b0100);
            if (ref_valid) seen2++;
            step(1, 3, '0, 4'b0100);
            if (ref_valid) seen3++;
        end
        chk(seen2 == 0, "R7 held during transfer", seen2, 0);
        chk(seen3 == 2, "R9 neighbour keeps its own period", seen3, 2);
        step(1, 2, '0, '0);
        chk(ref_valid == 1'b1, "R7 replay after transfer", int'(ref_valid), 1);
        step(1, 2, '0, '0);
        chk(ref_valid == 1'b0, "R8 only one owed refresh", int'(ref_valid), 0);

        // ---- R5 wrap with four rows
        do_reset(1'b1);
        n = 0; last_b = -1; last_r = -1;
        while (n < 9) begin
            step(1, 0, '0, '0);
            if (ref_valid) begin
                n++;
                if (n == 8) chk(ref_bank == 1 && ref_row == 3, "R5 last pair before wrap",
                                int'(ref_bank) * 100 + int'(ref_row), 103);
                if (n == 9) chk(ref_bank == 0 && ref_row == 0, "R5 wrap to start",
                                int'(ref_bank) * 100 + int'(ref_row), 0);
            end
        end

        // ---- R10 random traffic with bounded blocking, both modes
        for (int pass = 0; pass < 2; pass++) begin
            do_reset(pass[0]);
            for (int r = 0; r < NR; r++) begin xleft[r] = 0; xcool[r] = 0; end
            preq = '0;
            for (int i = 0; i < 20000; i++) begin
                int       res;
                bit       go;
                logic [3:0] rq, xf;
                go  = ($urandom_range(9) != 0);
                res = $urandom_range(NR - 1);
                for (int r = 0; r < NR; r++) begin
                    if (xleft[r] > 0) xleft[r]--;
                    else if (xcool[r] > 0) xcool[r]--;
                    else if ($urandom_range(99) == 0) begin
                        xleft[r] = $urandom_range(20, 1);
                        xcool[r] = 60;
                    end
                    xf[r] = (xleft[r] > 0);
                    rq[r] = ($urandom_range(4) == 0);
                end
                if (go && preq[res]) rq[res] = 1'b0;
                if (go) preq[res] = rq[res];
                step(go, res, rq, xf);
                if (ref_valid) begin
                    chk(gap[ref_res] <= 2 * (pass ? L8 : L4), "R10 refresh gap bound",
                        gap[ref_res], 2 * (pass ? L8 : L4));
                    gap[ref_res] = 0;
                end
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule